// File: doc/BRIEF.md
# Root Port Link Bring-up Sequencer

This block walks a PCIe root-port controller from full reset to a trained link with no software in the loop. After a start command it selects root-complex operation, lifts powerdown and then the soft reset, and gives the controller a fixed settling interval. It then asks the PHY to initialise while keeping link training disabled. When the PHY reports ready, it can optionally pulse the active-low fundamental reset (PERST#) to the downstream device, enables link training, and waits for link-up. It finally opens configuration access, after a long quiet period if PERST# was pulsed.

Every interval is a whole number of clock cycles, derived from a clock-frequency parameter and a time in microseconds, rounded up. The PHY-ready wait and the link-up wait each have their own cycle-count timeout. When one expires, the sequencer parks in an error state until the next start command. A start command in any state, or the synchronous reset, puts all control lines back to the reset-held, training-off condition.

Top module: `rp_link_seq`

## Requirements
- R1: During and after reset, and in the idle state: rc_mode_o=0, pwr_down_o=1, soft_rst_o=1, phy_init_o=0, perst_n_o=1, ltssm_en_o=0, cfg_allowed_o=0, done_o=0, error_o=0. A reset applied in the middle of a sequence restores this pattern on the next clock edge.
- R2: When start_i is sampled high at edge t0, the outputs follow a fixed order. rc_mode_o rises after edge t0. pwr_down_o falls after edge t0+1. soft_rst_o falls after edge t0+2.
- R3: phy_init_o rises exactly SETTLE_CYC cycles after soft_rst_o falls. SETTLE_CYC = ceil(CLK_HZ*SETTLE_US/1e6), with SETTLE_US=1000 by default, which gives between 1 ms and 2 ms for any clock of at least 1 kHz.
- R4: ltssm_en_o is low for as long as phy_init_o is high, and at every step before the PHY reports ready.
- R5: phy_init_o stays high until phy_ready_i is sampled high. A ready seen on the last cycle of the window is still accepted. If PHY_TMO_CYC cycles pass after phy_init_o rises with no ready, the outputs go to the error pattern (the R1 pattern with error_o=1).
- R6: perst_en_i is sampled only on the start edge. When it was high, perst_n_o goes low on the edge that accepts phy_ready_i and stays low for exactly PERST_CYC = ceil(CLK_HZ*PERST_US/1e6) cycles (PERST_US=100 by default).
- R7: With PERST# in use, ltssm_en_o rises one cycle after perst_n_o returns high. Without it, ltssm_en_o rises on the edge that accepts phy_ready_i. ltssm_en_o is never high while perst_n_o is low.
- R8: If link_up_i is not sampled high within LINK_TMO_CYC cycles of ltssm_en_o rising, the outputs go to the error pattern. A link-up seen on the last cycle of the window is still accepted.
- R9: With PERST# in use, cfg_allowed_o and done_o rise together exactly GATE_CYC = ceil(CLK_HZ*GATE_US/1e6) cycles after link-up is accepted (GATE_US=100000). cfg_allowed_o is high only together with done_o and ltssm_en_o.
- R10: Without PERST#, cfg_allowed_o and done_o rise on the edge that accepts link_up_i.
- R11: start_i sampled high in any state restarts the sequence. On the next edge the outputs are rc_mode_o=1, pwr_down_o=1, soft_rst_o=1, with everything else low and perst_n_o high.
- R12: In the error state, phy_ready_i and link_up_i have no effect. The error pattern holds until start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin (or restart) the bring-up sequence |
| perst_en_i | input | 1 | Use the PERST# pulse and post-link quiet period; sampled at start |
| phy_ready_i | input | 1 | PHY initialisation complete |
| link_up_i | input | 1 | Link training reports link up |
| rc_mode_o | output | 1 | Root-complex device-type select |
| pwr_down_o | output | 1 | Controller held in powerdown |
| soft_rst_o | output | 1 | Controller held in soft reset |
| phy_init_o | output | 1 | PHY initialisation request |
| perst_n_o | output | 1 | Active-low fundamental reset to the downstream device |
| ltssm_en_o | output | 1 | Link training enable |
| cfg_allowed_o | output | 1 | Configuration traffic permitted |
| done_o | output | 1 | Sequence completed |
| error_o | output | 1 | A wait timed out |

## Verification
The bench builds the block with CLK_HZ=100000, so one cycle stands for 10 us. The settle interval becomes 100 cycles, the PERST# pulse 10 cycles and the post-link quiet period 10000 cycles. Each of these can then be checked to the exact edge, and several full sequences fit in one short run. PHY_TMO_CYC=40 and LINK_TMO_CYC=300 are small enough that both timeouts, and a ready or link-up arriving on the very last cycle of each window, can be driven directly.

// File: rtl/rp_link_pkg.sv
package rp_link_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TYPE, ST_PWR, ST_SETTLE, ST_PHY, ST_PERST,
    ST_REL, ST_LINK, ST_GATE, ST_DONE, ST_ERR
  } seq_state_e;

  typedef struct packed {
    logic rc;    // root-complex select
    logic pd;    // powerdown held
    logic sr;    // soft reset held
    logic phy;   // phy init request
    logic pn;    // PERST# (active low)
    logic lt;    // link training enable
    logic cfg;   // configuration allowed
    logic dn;    // done
    logic er;    // error
  } ctl_t;

  function automatic ctl_t ctl_decode(seq_state_e s);
    ctl_t c;
    c = '{rc: 1'b0, pd: 1'b1, sr: 1'b1, phy: 1'b0, pn: 1'b1,
          lt: 1'b0, cfg: 1'b0, dn: 1'b0, er: 1'b0};
    case (s)
      ST_TYPE:   c.rc = 1'b1;
      ST_PWR:    begin c.rc = 1'b1; c.pd = 1'b0; end
      ST_SETTLE: begin c.rc = 1'b1; c.pd = 1'b0; c.sr = 1'b0; end
      ST_PHY:    begin c.rc = 1'b1; c.pd = 1'b0; c.sr = 1'b0; c.phy = 1'b1; end
      ST_PERST:  begin c.rc = 1'b1; c.pd = 1'b0; c.sr = 1'b0; c.pn = 1'b0; end
      ST_REL:    begin c.rc = 1'b1; c.pd = 1'b0; c.sr = 1'b0; end
      ST_LINK,
      ST_GATE:   begin c.rc = 1'b1; c.pd = 1'b0; c.sr = 1'b0; c.lt = 1'b1; end
      ST_DONE:   begin
        c.rc = 1'b1; c.pd = 1'b0; c.sr = 1'b0; c.lt = 1'b1;
        c.cfg = 1'b1; c.dn = 1'b1;
      end
      ST_ERR:    c.er = 1'b1;
      default:   ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rp_dwell_timer.sv
module rp_dwell_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // the count parks at zero until reloaded (interval end is stable)
  assert_cnt_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

  // a load always lands the requested value
  assert_cnt_load_R3: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/rp_seq_ctrl.sv
module rp_seq_ctrl
  import rp_link_pkg::*;
#(
  parameter int              CNT_W      = 8,
  parameter longint unsigned SETTLE_CYC = 100,
  parameter longint unsigned PERST_CYC  = 10,
  parameter longint unsigned GATE_CYC   = 100,
  parameter longint unsigned PHY_TMO    = 40,
  parameter longint unsigned LINK_TMO   = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             perst_en_i,
  input  logic             phy_ready_i,
  input  logic             link_up_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output ctl_t             ctl_o
);

  localparam logic [CNT_W-1:0] V_SETTLE = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] V_PERST  = CNT_W'(PERST_CYC - 1);
  localparam logic [CNT_W-1:0] V_GATE   = CNT_W'(GATE_CYC - 1);
  localparam logic [CNT_W-1:0] V_PHY    = CNT_W'(PHY_TMO - 1);
  localparam logic [CNT_W-1:0] V_LINK   = CNT_W'(LINK_TMO - 1);

  seq_state_e st_q, st_d;
  logic       perst_q;
  ctl_t       ctl_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_TYPE:   st_d = ST_PWR;
      ST_PWR:    st_d = ST_SETTLE;
      ST_SETTLE: if (tmr_zero_i) st_d = ST_PHY;
      ST_PHY: begin
        if (phy_ready_i)     st_d = perst_q ? ST_PERST : ST_LINK;
        else if (tmr_zero_i) st_d = ST_ERR;
      end
      ST_PERST:  if (tmr_zero_i) st_d = ST_REL;
      ST_REL:    st_d = ST_LINK;
      ST_LINK: begin
        if (link_up_i)       st_d = perst_q ? ST_GATE : ST_DONE;
        else if (tmr_zero_i) st_d = ST_ERR;
      end
      ST_GATE:   if (tmr_zero_i) st_d = ST_DONE;
      default:   ;
    endcase
    if (start_i) st_d = ST_TYPE;
  end

  always_comb begin
    tmr_load_o = (st_d != st_q);
    case (st_d)
      ST_SETTLE: tmr_val_o = V_SETTLE;
      ST_PHY:    tmr_val_o = V_PHY;
      ST_PERST:  tmr_val_o = V_PERST;
      ST_LINK:   tmr_val_o = V_LINK;
      ST_GATE:   tmr_val_o = V_GATE;
      default:   tmr_val_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      perst_q <= 1'b0;
      ctl_q   <= ctl_decode(ST_IDLE);
    end else begin
      st_q  <= st_d;
      ctl_q <= ctl_decode(st_d);
      if (start_i) perst_q <= perst_en_i;
    end
  end

  assign ctl_o = ctl_q;

  assert_pwr_after_type_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.pd |-> ctl_q.rc);

  assert_srst_after_pwr_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.sr |-> !ctl_q.pd);

  assert_ltssm_off_phy_R4: assert property (@(posedge clk) disable iff (rst)
    ctl_q.phy |-> !ctl_q.lt);

  assert_ltssm_off_perst_R7: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.pn |-> !ctl_q.lt);

  assert_cfg_only_done_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_q.cfg |-> (ctl_q.dn && ctl_q.lt && !ctl_q.er));

  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (ctl_q.rc && ctl_q.pd && ctl_q.sr && !ctl_q.lt && !ctl_q.cfg && !ctl_q.er));

  assert_err_park_R12: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.er && !start_i) |=> ctl_q.er);

endmodule

// File: rtl/rp_link_seq.sv
module rp_link_seq
  import rp_link_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 100_000_000,
  parameter longint unsigned SETTLE_US    = 1000,
  parameter longint unsigned PERST_US     = 100,
  parameter longint unsigned GATE_US      = 100_000,
  parameter longint unsigned PHY_TMO_CYC  = 1_000_000,
  parameter longint unsigned LINK_TMO_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic perst_en_i,
  input  logic phy_ready_i,
  input  logic link_up_i,
  output logic rc_mode_o,
  output logic pwr_down_o,
  output logic soft_rst_o,
  output logic phy_init_o,
  output logic perst_n_o,
  output logic ltssm_en_o,
  output logic cfg_allowed_o,
  output logic done_o,
  output logic error_o
);

  localparam longint unsigned MHZ_DIV = 64'd1_000_000;
  localparam longint unsigned S_RAW = (CLK_HZ * SETTLE_US + MHZ_DIV - 1) / MHZ_DIV;
  localparam longint unsigned P_RAW = (CLK_HZ * PERST_US  + MHZ_DIV - 1) / MHZ_DIV;
  localparam longint unsigned G_RAW = (CLK_HZ * GATE_US   + MHZ_DIV - 1) / MHZ_DIV;
  localparam longint unsigned S_CYC = (S_RAW == 0) ? 1 : S_RAW;
  localparam longint unsigned P_CYC = (P_RAW == 0) ? 1 : P_RAW;
  localparam longint unsigned G_CYC = (G_RAW == 0) ? 1 : G_RAW;
  localparam longint unsigned PT_CYC = (PHY_TMO_CYC  == 0) ? 1 : PHY_TMO_CYC;
  localparam longint unsigned LT_CYC = (LINK_TMO_CYC == 0) ? 1 : LINK_TMO_CYC;
  localparam longint unsigned M1 = (S_CYC > P_CYC) ? S_CYC : P_CYC;
  localparam longint unsigned M2 = (G_CYC > M1) ? G_CYC : M1;
  localparam longint unsigned M3 = (PT_CYC > M2) ? PT_CYC : M2;
  localparam longint unsigned MAX_CYC = (LT_CYC > M3) ? LT_CYC : M3;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  ctl_t             ctl;

  rp_seq_ctrl #(
    .CNT_W      (CNT_W),
    .SETTLE_CYC (S_CYC),
    .PERST_CYC  (P_CYC),
    .GATE_CYC   (G_CYC),
    .PHY_TMO    (PT_CYC),
    .LINK_TMO   (LT_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .perst_en_i  (perst_en_i),
    .phy_ready_i (phy_ready_i),
    .link_up_i   (link_up_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .ctl_o       (ctl)
  );

  rp_dwell_timer #(.W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign rc_mode_o     = ctl.rc;
  assign pwr_down_o    = ctl.pd;
  assign soft_rst_o    = ctl.sr;
  assign phy_init_o    = ctl.phy;
  assign perst_n_o     = ctl.pn;
  assign ltssm_en_o    = ctl.lt;
  assign cfg_allowed_o = ctl.cfg;
  assign done_o        = ctl.dn;
  assign error_o       = ctl.er;

endmodule

// File: tb/rp_link_seq_test.sv
module rp_link_seq_test;

  localparam longint unsigned TB_HZ = 100_000;
  localparam int S  = (TB_HZ * 1000   + 999_999) / 1_000_000;  // 100
  localparam int P  = (TB_HZ * 100    + 999_999) / 1_000_000;  // 10
  localparam int G  = (TB_HZ * 100000 + 999_999) / 1_000_000;  // 10000
  localparam int PT = 40;
  localparam int LT = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, perst_opt = 1'b0, phy_ready = 1'b0, link_up = 1'b0;
  logic rc, pd, sr, ph, pn, lt, cf, dn, er;

  always #2 clk = ~clk;  // 250 MHz

  rp_link_seq #(
    .CLK_HZ(TB_HZ), .PHY_TMO_CYC(PT), .LINK_TMO_CYC(LT)
  ) uut (
    .clk(clk), .rst(rst), .start_i(start), .perst_en_i(perst_opt),
    .phy_ready_i(phy_ready), .link_up_i(link_up),
    .rc_mode_o(rc), .pwr_down_o(pd), .soft_rst_o(sr), .phy_init_o(ph),
    .perst_n_o(pn), .ltssm_en_o(lt), .cfg_allowed_o(cf), .done_o(dn),
    .error_o(er)
  );

  typedef struct {
    int         cyc;
    logic [8:0] vec;
    string      req;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  int    last_t = 0;
  bit    mon_en = 0, finished = 0;
  string cur_req = "R1";
  logic [8:0] prev;

  function automatic logic [8:0] mk(bit a, b, c, d, e, f, g, h, i);
    return {a, b, c, d, e, f, g, h, i};
  endfunction

  localparam logic [8:0] V_IDLE = 9'b011010000;
  localparam logic [8:0] V_ERR  = 9'b011010001;
  localparam logic [8:0] V_TYPE = 9'b111010000;
  localparam logic [8:0] V_DONE = 9'b100011110;

  wire [8:0] vec = {rc, pd, sr, ph, pn, lt, cf, dn, er};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int t, logic [8:0] v, string r);
    exp_t e;
    e.cyc = t; e.vec = v; e.req = r;
    q.push_back(e);
    if (t > last_t) last_t = t;
  endtask

  // monitor: every output change must match the head of the scoreboard
  always @(negedge clk) begin
    if (mon_en && vec !== prev) begin
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: unexpected change at cycle %0d actual=%b expected=%b",
                 cur_req, cyc, vec, prev);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.cyc != cyc || e.vec !== vec) begin
          n_fail++;
          $display("FAIL %s: actual cycle %0d vec %b, expected cycle %0d vec %b",
                   e.req, cyc, vec, e.cyc, e.vec);
        end
      end
      prev = vec;
    end
  end

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain();
    wait_until(last_t + 5);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d expected changes missing, actual vec %b expected %b",
               q[0].req, q.size(), vec, q[0].vec);
      q.delete();
    end
  endtask

  task automatic run_seq(bit per, int dp, int dl, bit phy_ok, bit link_ok, bit flip);
    int t0, e, tp, le, tl;
    @(negedge clk);
    phy_ready = 1'b0; link_up = 1'b0;
    perst_opt = per; start = 1'b1;
    t0 = cyc + 1;
    cur_req = "R2";
    push(t0,     V_TYPE, "R2");
    push(t0 + 1, mk(1,0,1,0,1,0,0,0,0), "R2");
    push(t0 + 2, mk(1,0,0,0,1,0,0,0,0), "R2");
    e = t0 + 2 + S;
    push(e, mk(1,0,0,1,1,0,0,0,0), "R3");
    tp = e + dp; le = 0; tl = 0;
    if (!phy_ok) push(e + PT, V_ERR, "R5");
    else begin
      if (per) begin
        push(tp,     mk(1,0,0,0,0,0,0,0,0), "R6");
        push(tp + P, mk(1,0,0,0,1,0,0,0,0), "R6");
        le = tp + P + 1;
        push(le,     mk(1,0,0,0,1,1,0,0,0), "R7");
      end else begin
        le = tp;
        push(le, mk(1,0,0,0,1,1,0,0,0), "R7");
      end
      tl = le + dl;
      if (!link_ok) push(le + LT, V_ERR, "R8");
      else if (per) push(tl + G, V_DONE, "R9");
      else push(tl, V_DONE, "R10");
    end
    @(negedge clk);
    start = 1'b0;
    if (flip) perst_opt = !per;  // ignored after the start edge (R6)
    if (phy_ok) begin
      wait_until(tp - 1);
      phy_ready = 1'b1;
      if (link_ok) begin
        wait_until(tl - 1);
        link_up = 1'b1;
      end
    end
    drain();
  endtask

  task automatic run_abort(output int t0);
    @(negedge clk);
    phy_ready = 1'b0; link_up = 1'b0; start = 1'b1;
    t0 = cyc + 1;
    push(t0,     V_TYPE, "R11");
    push(t0 + 1, mk(1,0,1,0,1,0,0,0,0), "R11");
    push(t0 + 2, mk(1,0,0,0,1,0,0,0,0), "R11");
    @(negedge clk);
    start = 1'b0;
    wait_until(t0 + 10);
  endtask

  task automatic err_ignore();
    cur_req = "R12";
    @(negedge clk);
    phy_ready = 1'b1; link_up = 1'b1;
    repeat (30) @(negedge clk);
    n_chk++;
    if (er !== 1'b1 || vec !== V_ERR) begin
      n_fail++;
      $display("FAIL R12: error pattern not held, actual %b expected %b", vec, V_ERR);
    end
    phy_ready = 1'b0; link_up = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual cycle %0d expected below 150000", cyc);
    finish_run();
  end

  initial begin
    int ta;
    repeat (5) @(negedge clk);
    n_chk++;
    if (vec !== V_IDLE) begin
      n_fail++;
      $display("FAIL R1: reset pattern actual %b expected %b", vec, V_IDLE);
    end
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (vec !== V_IDLE) begin
      n_fail++;
      $display("FAIL R1: idle pattern actual %b expected %b", vec, V_IDLE);
    end
    prev = vec;
    mon_en = 1;

    run_seq(1, 5, 20, 1, 1, 0);          // full sequence with PERST#: R2 R3 R4 R6 R7 R9
    run_seq(0, 3, 7, 1, 1, 0);           // no PERST#: R7 R10
    run_seq(0, PT, LT, 1, 1, 1);         // last-cycle ready and link-up, option flipped after start: R5 R6 R8
    run_seq(1, 0, 0, 0, 1, 0);           // phy timeout: R5
    err_ignore();                        // R12
    run_seq(1, 4, 0, 1, 0, 0);           // link timeout: R8
    err_ignore();                        // R12
    run_abort(ta);                       // restart mid-settle: R11
    run_seq(1, 2, 3, 1, 1, 0);
    run_abort(ta);                       // reset mid-sequence: R1
    @(negedge clk);
    cur_req = "R1";
    rst = 1'b1;
    push(cyc + 1, V_IDLE, "R1");
    @(negedge clk);
    rst = 1'b0;
    drain();
    run_seq(0, 1, 1, 1, 1, 0);
    finish_run();
  end

endmodule